// File: doc/BRIEF.md
# Phase-Frequency Detector With Pump Control

This block compares two single-cycle pulse streams, the divided reference (`ref_pulse`) and the divided oscillator (`div_pulse`), and turns their arrival order into source and sink requests for an external charge pump. Each input sets its own request flop. When both flops are set, they stay high together for a fixed minimum overlap of `MIN_PULSE` clocks and then clear in the same cycle. A locked loop therefore still shows short, equal source and sink pulses. A pulse that arrives while its own flop is already set is absorbed, which limits the detection range to one full input period of lead or lag.

Programmable controls sit after the detector:
- a sign bit swaps source and sink;
- a 2-bit mode field can replace detector control with a constant source, a constant sink or high impedance;
- a 2-bit current code passes through to the analog pump.

A lock monitor counts consecutive comparisons with a narrow one-sided pulse. A selectable diagnostic pin can carry lock status, a constant low, a serial readback bit, or either raw pulse stream. When `synth_en` is low, the detector and lock monitor are cleared and the pump output is high impedance.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: After reset with `synth_en`=1, mode 00 and `ld_sel`=000, the outputs are `pump_src`=0, `pump_snk`=0, `pump_hiz`=1 and `ld_pin`=0.
- R2: With `pump_sign`=0 and mode 00, when `ref_pulse` leads `div_pulse` by d clocks, `pump_src` alone is high for exactly d clocks, starting the cycle after the `ref_pulse` clock. When `div_pulse` leads, `pump_snk` alone is high for d clocks.
- R3: With `pump_sign`=1, the roles in R2 are swapped: a leading `ref_pulse` gives `pump_snk`, and a leading `div_pulse` gives `pump_src`.
- R4: Once both request flops are set, `pump_src` and `pump_snk` are both high for exactly `MIN_PULSE` (2) clocks and then fall together. Pulses arriving in the same cycle produce only this overlap.
- R5: A second `ref_pulse` that arrives while the reference request is still pending has no effect. After the comparison clears, both pump outputs stay low.
- R6: The mode codes are:
  - 00: detector controls the pump;
  - 01: `pump_src`=1 and `pump_snk`=0;
  - 10: `pump_snk`=1 and `pump_src`=0;
  - 11: both low and `pump_hiz`=1.
  
  `pump_hiz` is high exactly when neither pump output is high. Changing the mode does not disturb a pending comparison.
- R7: `cur_code` equals `cur_sel` for each code 00 (0.25 mA), 01 (0.50 mA), 10 (0.75 mA) and 11 (1.00 mA).
- R8: With `ld_sel`=000, `ld_pin` rises at the clearing edge of the `LOCK_COUNT`-th (8th) consecutive comparison whose one-sided width is at most `LOCK_TOL` (4) clocks.
- R9: A comparison with a one-sided width greater than `LOCK_TOL` drops `ld_pin` at its clearing edge and restarts the count.
- R10: `ld_sel` selects the `ld_pin` source:
  - 000: lock status;
  - 001: low;
  - 010: `readback_bit`;
  - 011: `ref_pulse`;
  - 100: `div_pulse`;
  - any other code: low.
- R11: While `synth_en`=0, the pump is high impedance (`pump_hiz`=1, `pump_src`=`pump_snk`=0) and lock status is 0. A pending request does not survive re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| synth_en | input | 1 | Synthesizer enable |
| ref_pulse | input | 1 | Divided reference pulse, one clock wide |
| div_pulse | input | 1 | Divided oscillator pulse, one clock wide |
| pump_sign | input | 1 | 0: leading reference sources, 1: reversed |
| pump_mode | input | 2 | Pump mode / test override code |
| cur_sel | input | 2 | Pump current setting |
| ld_sel | input | 3 | Diagnostic pin source select |
| readback_bit | input | 1 | Serial register readback bit |
| pump_src | output | 1 | Pump source enable |
| pump_snk | output | 1 | Pump sink enable |
| pump_hiz | output | 1 | Pump output high impedance |
| cur_code | output | 2 | Current code to analog pump |
| ld_pin | output | 1 | Multiplexed diagnostic output |

## Verification
Two functions can land in the same cycle: a mode override and a detector request that is still pending.

The bench starts a comparison, then switches the mode to high impedance and back to normal before the lagging pulse arrives. It expects the ports to follow the override while it is active. Once the mode returns to normal, it expects the pending request to appear again with the original timing, closing with the normal overlap.

A second coincidence is tested separately: both input pulses arrive in the same cycle. For that case the bench expects an overlap only, with zero one-sided width, and counts it as a qualifying lock comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PM_NORMAL = 2'b00,
      PM_SOURCE = 2'b01,
      PM_SINK   = 2'b10,
      PM_HIZ    = 2'b11
   } pump_mode_e;

   typedef enum logic [2:0] {
      LD_LOCK   = 3'b000,
      LD_LOW    = 3'b001,
      LD_RDBK   = 3'b010,
      LD_REF    = 3'b011,
      LD_DIV    = 3'b100
   } ld_src_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter int MIN_PULSE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ref_pulse,
   input  logic div_pulse,
   output logic up,
   output logic dn,
   output logic cmp_done
);
   logic up_q, dn_q, both;

   initial begin : elab_chk
      assert (MIN_PULSE >= 1);
   end

   assign both = up_q && dn_q;
   assign up   = up_q;
   assign dn   = dn_q;

   generate
      if (MIN_PULSE == 1) begin : g_single
         assign cmp_done = both;
      end else begin : g_counted
         localparam int CW = $clog2(MIN_PULSE);
         logic [CW-1:0] ovl_q;
         assign cmp_done = both && (ovl_q == CW'(MIN_PULSE - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !en || !both || cmp_done) ovl_q <= '0;
            else                                     ovl_q <= ovl_q + 1'b1;
         end
         // overlap lasts at least two clocks
         p_min_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (both && !cmp_done && en) |=> (up_q && dn_q));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !en || cmp_done) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (!both) begin
         up_q <= up_q | ref_pulse;
         dn_q <= dn_q | div_pulse;
      end
   end

   p_clear_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q) |=> (up_q == dn_q));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
   parameter int LOCK_TOL   = 4,
   parameter int LOCK_COUNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic up,
   input  logic dn,
   input  logic cmp_done,
   output logic locked
);
   localparam int WW = $clog2(LOCK_TOL + 2);
   localparam int GW = $clog2(LOCK_COUNT + 1);

   logic [WW-1:0] width_q;
   logic [GW-1:0] good_q, good_nx;
   logic          lock_q, narrow;

   initial begin : elab_chk
      assert (LOCK_TOL >= 0 && LOCK_COUNT >= 1);
   end

   assign narrow  = (width_q <= WW'(LOCK_TOL));
   assign good_nx = (good_q == GW'(LOCK_COUNT)) ? good_q : good_q + 1'b1;
   assign locked  = lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         width_q <= '0;
         good_q  <= '0;
         lock_q  <= 1'b0;
      end else if (cmp_done) begin
         width_q <= '0;
         if (narrow) begin
            good_q <= good_nx;
            lock_q <= (good_nx == GW'(LOCK_COUNT));
         end else begin
            good_q <= '0;
            lock_q <= 1'b0;
         end
      end else if ((up ^ dn) && narrow) begin
         width_q <= width_q + 1'b1;
      end
   end

   p_lock_on_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(cmp_done));
   p_dis_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !lock_q);
endmodule

// File: rtl/pump_mux.sv
module pump_mux
   import pfd_pkg::*;
#(
   parameter int CUR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             up,
   input  logic             dn,
   input  logic             sign,
   input  logic [1:0]       mode,
   input  logic [CUR_W-1:0] cur_sel,
   input  logic [2:0]       ld_sel,
   input  logic             locked,
   input  logic             readback_bit,
   input  logic             ref_pulse,
   input  logic             div_pulse,
   output logic             pump_src,
   output logic             pump_snk,
   output logic             pump_hiz,
   output logic [CUR_W-1:0] cur_code,
   output logic             ld_pin
);
   logic det_src, det_snk;

   assign det_src  = sign ? dn : up;
   assign det_snk  = sign ? up : dn;
   assign cur_code = cur_sel;

   always_comb begin
      pump_src = 1'b0;
      pump_snk = 1'b0;
      pump_hiz = 1'b1;
      if (en) begin
         unique case (pump_mode_e'(mode))
            PM_NORMAL: begin
               pump_src = det_src;
               pump_snk = det_snk;
               pump_hiz = !up && !dn;
            end
            PM_SOURCE: begin pump_src = 1'b1; pump_hiz = 1'b0; end
            PM_SINK:   begin pump_snk = 1'b1; pump_hiz = 1'b0; end
            default:   pump_hiz = 1'b1;
         endcase
      end
   end

   always_comb begin
      case (ld_sel)
         LD_LOCK: ld_pin = locked;
         LD_RDBK: ld_pin = readback_bit;
         LD_REF:  ld_pin = ref_pulse;
         LD_DIV:  ld_pin = div_pulse;
         default: ld_pin = 1'b0;
      endcase
   end

   p_hiz_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pump_hiz |-> (!pump_src && !pump_snk));
   p_dis_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pump_hiz && !pump_src && !pump_snk));
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
   parameter int MIN_PULSE  = 2,
   parameter int LOCK_TOL   = 4,
   parameter int LOCK_COUNT = 8,
   parameter int CUR_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             synth_en,
   input  logic             ref_pulse,
   input  logic             div_pulse,
   input  logic             pump_sign,
   input  logic [1:0]       pump_mode,
   input  logic [CUR_W-1:0] cur_sel,
   input  logic [2:0]       ld_sel,
   input  logic             readback_bit,
   output logic             pump_src,
   output logic             pump_snk,
   output logic             pump_hiz,
   output logic [CUR_W-1:0] cur_code,
   output logic             ld_pin
);
   logic up, dn, cmp_done, locked;

   initial begin : elab_chk
      assert (CUR_W >= 1);
   end

   pfd_core #(.MIN_PULSE(MIN_PULSE)) i_core (
      .clk(clk), .rst_n(rst_n), .en(synth_en),
      .ref_pulse(ref_pulse), .div_pulse(div_pulse),
      .up(up), .dn(dn), .cmp_done(cmp_done));

   lock_monitor #(.LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT)) i_lock (
      .clk(clk), .rst_n(rst_n), .en(synth_en),
      .up(up), .dn(dn), .cmp_done(cmp_done), .locked(locked));

   pump_mux #(.CUR_W(CUR_W)) i_mux (
      .clk(clk), .rst_n(rst_n), .en(synth_en), .up(up), .dn(dn),
      .sign(pump_sign), .mode(pump_mode), .cur_sel(cur_sel), .ld_sel(ld_sel),
      .locked(locked), .readback_bit(readback_bit),
      .ref_pulse(ref_pulse), .div_pulse(div_pulse),
      .pump_src(pump_src), .pump_snk(pump_snk), .pump_hiz(pump_hiz),
      .cur_code(cur_code), .ld_pin(ld_pin));
endmodule

// File: tb/test_pfd_pump_ctrl.sv
module test_pfd_pump_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       synth_en = 1'b1;
   logic       ref_pulse = 1'b0, div_pulse = 1'b0;
   logic       pump_sign = 1'b0;
   logic [1:0] pump_mode = 2'b00;
   logic [1:0] cur_sel = 2'b00;
   logic [2:0] ld_sel = 3'b000;
   logic       readback_bit = 1'b0;
   logic       pump_src, pump_snk, pump_hiz, ld_pin;
   logic [1:0] cur_code;

   int checks = 0, errors = 0;
   int good = 0;  // model: consecutive narrow comparisons
   localparam int TOL = 4, NEED = 8;

   always #10 clk = ~clk;

   pfd_pump_ctrl i_pfd_pump_ctrl (
      .clk(clk), .rst_n(rst_n), .synth_en(synth_en),
      .ref_pulse(ref_pulse), .div_pulse(div_pulse), .pump_sign(pump_sign),
      .pump_mode(pump_mode), .cur_sel(cur_sel), .ld_sel(ld_sel),
      .readback_bit(readback_bit), .pump_src(pump_src), .pump_snk(pump_snk),
      .pump_hiz(pump_hiz), .cur_code(cur_code), .ld_pin(ld_pin));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_lock(input int g);
      return g >= NEED;
   endfunction

   // one comparison; the leading pulse d clocks before the lagging one
   task automatic compare(input int d, input bit fr_first, input string req);
      int one = 0, ovl = 0, bad = 0;
      bit src_side = fr_first ^ pump_sign;
      @(negedge clk);
      if (fr_first || d == 0) ref_pulse = 1'b1;
      if (!fr_first || d == 0) div_pulse = 1'b1;
      for (int k = 1; k <= d + 3; k++) begin
         @(negedge clk);
         ref_pulse = 1'b0; div_pulse = 1'b0;
         if (k <= d + 2) begin
            if (pump_src && pump_snk) ovl++;
            else if (src_side ? (pump_src && !pump_snk) : (pump_snk && !pump_src)) one++;
            else bad++;
         end else begin
            check(!pump_src && !pump_snk && pump_hiz, req, {pump_src, pump_snk, pump_hiz}, 3'b001);
         end
         if (k == d && d > 0) begin
            if (fr_first) div_pulse = 1'b1; else ref_pulse = 1'b1;
         end
      end
      check(one == d, req, one, d);
      check(ovl == 2 && bad == 0, "R4", ovl, 2);
      good = (d <= TOL) ? good + 1 : 0;
      if (ld_sel == 3'b000)
         check(ld_pin == exp_lock(good), d > TOL ? "R9" : "R8", ld_pin, exp_lock(good));
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!pump_src && !pump_snk && pump_hiz && !ld_pin, "R1",
            {pump_src, pump_snk, pump_hiz, ld_pin}, 4'b0010);

      // R2 / R3 polarity
      compare(3, 1'b1, "R2");
      compare(2, 1'b0, "R2");
      pump_sign = 1'b1;
      compare(3, 1'b1, "R3");
      compare(1, 1'b0, "R3");
      pump_sign = 1'b0;
      compare(0, 1'b1, "R4");

      // R8: reach eight narrow comparisons
      for (int i = 0; i < 4; i++) compare(2, 1'b1, "R8");
      check(ld_pin == 1'b1, "R8", ld_pin, 1);
      // R9 wide comparison drops lock
      compare(5, 1'b0, "R9");
      check(ld_pin == 1'b0, "R9", ld_pin, 0);
      for (int i = 0; i < 7; i++) compare(4, 1'b1, "R8");
      check(ld_pin == 1'b0, "R8", ld_pin, 0);
      compare(4, 1'b1, "R8");
      check(ld_pin == 1'b1, "R8", ld_pin, 1);

      // R5 second reference pulse absorbed
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      @(negedge clk); div_pulse = 1'b1;
      @(negedge clk); div_pulse = 1'b0;
      check(pump_src && pump_snk, "R5", {pump_src, pump_snk}, 3);
      repeat (2) @(negedge clk);
      check(!pump_src && !pump_snk, "R5", {pump_src, pump_snk}, 0);
      repeat (3) @(negedge clk);
      check(!pump_src && !pump_snk && pump_hiz, "R5", {pump_src, pump_snk}, 0);
      good++;

      // R6 overrides, then override over a pending comparison
      pump_mode = 2'b01; @(negedge clk);
      check(pump_src && !pump_snk && !pump_hiz, "R6", {pump_src, pump_snk, pump_hiz}, 3'b100);
      pump_mode = 2'b10; @(negedge clk);
      check(!pump_src && pump_snk && !pump_hiz, "R6", {pump_src, pump_snk, pump_hiz}, 3'b010);
      pump_mode = 2'b11; @(negedge clk);
      check(!pump_src && !pump_snk && pump_hiz, "R6", {pump_src, pump_snk, pump_hiz}, 3'b001);
      pump_mode = 2'b00;
      ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0; pump_mode = 2'b11;
      @(negedge clk);
      check(pump_hiz && !pump_src, "R6", {pump_src, pump_hiz}, 1);
      pump_mode = 2'b00;
      @(negedge clk);
      check(pump_src && !pump_snk && !pump_hiz, "R6", {pump_src, pump_snk, pump_hiz}, 3'b100);
      div_pulse = 1'b1;
      @(negedge clk); div_pulse = 1'b0;
      check(pump_src && pump_snk, "R6", {pump_src, pump_snk}, 3);
      repeat (2) @(negedge clk);
      check(!pump_src && !pump_snk && pump_hiz, "R6", {pump_src, pump_snk}, 0);
      good++;  // width 3 comparison

      // R7 current code
      for (int c = 0; c < 4; c++) begin
         cur_sel = 2'(c);
         #2 check(cur_code == 2'(c), "R7", cur_code, c);
         @(negedge clk);
      end

      // R10 diagnostic mux
      ld_sel = 3'b001; #2 check(ld_pin == 1'b0, "R10", ld_pin, 0);
      ld_sel = 3'b010; readback_bit = 1'b1; #2 check(ld_pin == 1'b1, "R10", ld_pin, 1);
      readback_bit = 1'b0; #2 check(ld_pin == 1'b0, "R10", ld_pin, 0);
      ld_sel = 3'b111; readback_bit = 1'b1; #2 check(ld_pin == 1'b0, "R10", ld_pin, 0);
      readback_bit = 1'b0;
      @(negedge clk);
      ld_sel = 3'b011; ref_pulse = 1'b1; #2 check(ld_pin == 1'b1, "R10", ld_pin, 1);
      @(negedge clk); ref_pulse = 1'b0;
      ld_sel = 3'b100; div_pulse = 1'b1; #2 check(ld_pin == 1'b1, "R10", ld_pin, 1);
      @(negedge clk); div_pulse = 1'b0;
      repeat (3) @(negedge clk);
      good++;  // width 1 comparison
      ld_sel = 3'b000;

      // R11 disable clears pending request and lock
      ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0; synth_en = 1'b0;
      #2 check(pump_hiz && !pump_src && !pump_snk, "R11", {pump_src, pump_snk, pump_hiz}, 1);
      @(negedge clk);
      check(ld_pin == 1'b0, "R11", ld_pin, 0);
      synth_en = 1'b1;
      @(negedge clk);
      check(!pump_src && !pump_snk && pump_hiz, "R11", {pump_src, pump_snk, pump_hiz}, 1);
      good = 0;

      // random comparisons
      for (int i = 0; i < 40; i++) begin
         int d = ($urandom_range(0, 9) == 0) ? int'($urandom_range(5, 7)) : int'($urandom_range(0, 4));
         pump_sign = 1'($urandom_range(0, 1));
         compare(d, 1'($urandom_range(0, 1)), pump_sign ? "R3" : "R2");
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule